// File: doc/BRIEF.md
# Sampling Converter Digital Bus Interface

This block is the digital front of a 14-bit sampling converter. It decides when a conversion begins, based on a start-convert strobe, a chip select and a mode strap. It runs a fixed-length timer that stands in for the analog core. At the end of the timer it captures the core's 14-bit code. It reports conversion status on a dedicated pin and serves the captured result over an 8-bit bus.

Each three-state pin is modelled as a data output plus an enable output. The status pin is modelled the same way. In one strap setting it behaves as a normal three-state driver. In the other it can only pull low, as an open-drain pin would. The result is left-justified across two byte reads: the upper eight bits come first, then the lower six bits followed by two zero bits. A second strap selects straight binary or twos complement coding.

Bus-side control inputs are taken through two-flop synchronizers. The core code arrives on a port that the surrounding model (or a testbench) drives.

Top module: `sadc_bus_if`

## Requirements
- R1: With `sync_mode`=1, a conversion starts only when `sc_n` falls while `cs_n` is low. If `sc_n` falls while `cs_n` is high, nothing starts.
- R2: With `sync_mode`=0, a falling `sc_n` starts a conversion whatever the level of `cs_n`.
- R3: If `sc_n` is still low when a conversion ends, the next conversion starts on that same edge, so conversions run back to back. `cont_warn` goes to 1 at the first such restart and drops within 3 cycles of `sc_n` returning high.
- R4: Internal status is 1 when idle and 0 while converting. It falls on the third rising edge after `sc_n` is first sampled low, and it stays low for exactly `CONV_CYCLES` cycles.
- R5: With `sync_mode`=1, `eoc_oe`=1 exactly when `cs_n`=0 and `stat_en_n`=0, and `eoc_o` then carries the status (1 idle, 0 converting). Otherwise `eoc_oe`=0.
- R6: With `sync_mode`=0 and `stat_en_n`=0, `eoc_oe`=1 with `eoc_o`=0 during a conversion, and `eoc_oe`=0 when idle. When `stat_en_n`=1, `eoc_oe`=0 at all times.
- R7: `db_oe`=1 exactly when both `cs_n` and `oe_n` are 0.
- R8: When `byte_hi`=0, `db_o` = result[13:6]. When `byte_hi`=1, `db_o` = {result[5:0], 2'b00}. After reset the result is all zeros.
- R9: With `bipolar`=0 the result equals `core_code`. With `bipolar`=1 the result equals `core_code` with bit 13 inverted, so core code 0x0000 gives 0x2000 and core code 0x2000 gives 0x0000.
- R10: The result register changes only on the edge where a conversion ends, which is the same edge on which status returns high. A read during a conversion returns the previous result.
- R11: A falling `sc_n` during an active conversion is ignored. It neither lengthens the conversion nor starts a new one.
- R12: For `PWRUP_CYCLES` cycles after reset is released, no conversion starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_mode | input | 1 | Strap: 1 = chip-select-gated starts and status; 0 = free starts with pull-down status |
| bipolar | input | 1 | Strap: 1 = twos complement result; 0 = straight binary |
| cs_n | input | 1 | Chip select, active low |
| sc_n | input | 1 | Start-convert strobe, acts on its falling edge |
| stat_en_n | input | 1 | Status pin enable, active low |
| oe_n | input | 1 | Data bus output enable, active low |
| byte_hi | input | 1 | Byte select: 0 = upper byte, 1 = lower bits plus zero padding |
| core_code | input | 14 | Offset-binary code from the converter core |
| eoc_o | output | 1 | Status pin data value |
| eoc_oe | output | 1 | Status pin drive enable |
| db_o | output | 8 | Data bus value |
| db_oe | output | 8 | Data bus drive enable, one per bit (all bits equal) |
| cont_warn | output | 1 | Flag for back-to-back conversions caused by a held-low start strobe |

## Verification
The end of one conversion and the start of the next can fall on the same edge. This happens when `sc_n` is held low, and the same edge also loads the result register. The bench holds `sc_n` low across several conversion lengths and swaps `core_code` between them. On the exact cycle each conversion ends, it checks three things: status has stayed low with no idle gap, `cont_warn` has risen, and the byte read back is the code present at the end of that particular conversion. In a separate scenario, a second strobe lands in the middle of a conversion; the end time must stay the same and no new conversion may follow.

// File: rtl/sadc_pkg.sv
`timescale 1ns/1ps
package sadc_pkg;
  localparam int CODE_W = 14;
  localparam int BYTE_W = 8;
  localparam int LOW_W  = CODE_W - BYTE_W;
  localparam int PAD_W  = BYTE_W - LOW_W;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // Offset-binary core code to output coding: bipolar flips the sign bit.
  function automatic code_t fmt_code(input code_t raw, input logic bip);
    code_t v;
    v = raw;
    if (bip) v[CODE_W-1] = ~raw[CODE_W-1];
    return v;
  endfunction

  // Left-justified byte selection with zero padding on the low read.
  function automatic byte_t pick_byte(input code_t r, input logic hi);
    if (hi) return {r[LOW_W-1:0], {PAD_W{1'b0}}};
    return r[CODE_W-1:LOW_W];
  endfunction
endpackage

// File: rtl/sadc_in_sync.sv
`timescale 1ns/1ps
module sadc_in_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[s] <= '1;
        else        stage_q[s] <= d_in;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[s] <= '1;
        else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/sadc_start_ctl.sv
`timescale 1ns/1ps
module sadc_start_ctl #(
  parameter int PWRUP_CYCLES = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_mode,
  input  logic cs_s,
  input  logic sc_s,
  input  logic busy,
  input  logic done_evt,
  output logic start_evt,
  output logic pwr_ok,
  output logic cont_warn
);
  localparam int PW_W = $clog2(PWRUP_CYCLES + 1) + 1;

  logic [PW_W-1:0] pwr_cnt;
  logic            sc_d;
  logic            sc_fall;
  logic            gate_ok;
  logic            retrig;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       pwr_cnt <= '0;
    else if (!pwr_ok) pwr_cnt <= pwr_cnt + 1'b1;

  assign pwr_ok = (pwr_cnt >= PW_W'(PWRUP_CYCLES));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sc_d <= 1'b1;
    else        sc_d <= sc_s;

  assign sc_fall   = sc_d & ~sc_s;
  assign gate_ok   = sync_mode ? ~cs_s : 1'b1;
  assign retrig    = done_evt & ~sc_s;
  assign start_evt = pwr_ok & gate_ok & ((~busy & sc_fall) | retrig);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 cont_warn <= 1'b0;
    else if (sc_s)              cont_warn <= 1'b0;
    else if (retrig && start_evt) cont_warn <= 1'b1;
endmodule

// File: rtl/sadc_conv_timer.sv
`timescale 1ns/1ps
module sadc_conv_timer
  import sadc_pkg::*;
#(
  parameter int CONV_CYCLES = 315
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_evt,
  input  logic  bipolar,
  input  code_t core_code,
  output logic  busy,
  output logic  done_evt,
  output code_t result_q
);
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign done_evt = busy && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start_evt) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (done_evt) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt  <= cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        result_q <= '0;
    else if (done_evt) result_q <= fmt_code(core_code, bipolar);
endmodule

// File: rtl/sadc_pin_drv.sv
`timescale 1ns/1ps
module sadc_pin_drv
  import sadc_pkg::*;
(
  input  logic  sync_mode,
  input  logic  cs_n,
  input  logic  stat_en_n,
  input  logic  oe_n,
  input  logic  byte_hi,
  input  logic  busy,
  input  code_t result_q,
  output logic  eoc_o,
  output logic  eoc_oe,
  output byte_t db_o,
  output byte_t db_oe
);
  logic bus_en;

  always_comb begin
    if (sync_mode) begin
      eoc_oe = ~cs_n & ~stat_en_n;
      eoc_o  = ~busy;
    end else begin
      eoc_oe = ~stat_en_n & busy;
      eoc_o  = 1'b0;
    end
  end

  assign bus_en = ~(cs_n | oe_n);
  assign db_oe  = {BYTE_W{bus_en}};
  assign db_o   = bus_en ? pick_byte(result_q, byte_hi) : '0;
endmodule

// File: rtl/sadc_bus_if.sv
`timescale 1ns/1ps
module sadc_bus_if
  import sadc_pkg::*;
#(
  parameter int CONV_CYCLES  = 315,
  parameter int PWRUP_CYCLES = 500,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sync_mode,
  input  logic                bipolar,
  input  logic                cs_n,
  input  logic                sc_n,
  input  logic                stat_en_n,
  input  logic                oe_n,
  input  logic                byte_hi,
  input  logic [CODE_W-1:0]   core_code,
  output logic                eoc_o,
  output logic                eoc_oe,
  output logic [BYTE_W-1:0]   db_o,
  output logic [BYTE_W-1:0]   db_oe,
  output logic                cont_warn
);
  logic [1:0] ctl_sync;
  logic       cs_sync;
  logic       sc_sync;
  logic       start_evt;
  logic       done_evt;
  logic       busy;
  logic       pwr_ok;
  code_t      result_q;

  sadc_in_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({cs_n, sc_n}),
    .d_out (ctl_sync)
  );
  assign cs_sync = ctl_sync[1];
  assign sc_sync = ctl_sync[0];

  sadc_start_ctl #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_start (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_mode (sync_mode),
    .cs_s      (cs_sync),
    .sc_s      (sc_sync),
    .busy      (busy),
    .done_evt  (done_evt),
    .start_evt (start_evt),
    .pwr_ok    (pwr_ok),
    .cont_warn (cont_warn)
  );

  sadc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_evt (start_evt),
    .bipolar   (bipolar),
    .core_code (core_code),
    .busy      (busy),
    .done_evt  (done_evt),
    .result_q  (result_q)
  );

  sadc_pin_drv u_pins (
    .sync_mode (sync_mode),
    .cs_n      (cs_n),
    .stat_en_n (stat_en_n),
    .oe_n      (oe_n),
    .byte_hi   (byte_hi),
    .busy      (busy),
    .result_q  (result_q),
    .eoc_o     (eoc_o),
    .eoc_oe    (eoc_oe),
    .db_o      (db_o),
    .db_oe     (db_oe)
  );
endmodule

// File: rtl/sadc_bus_if_chk.sv
`timescale 1ns/1ps
module sadc_bus_if_chk
  import sadc_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  sync_mode,
  input logic  cs_s,
  input logic  start_evt,
  input logic  done_evt,
  input logic  busy,
  input logic  pwr_ok,
  input code_t result_q,
  input logic  eoc_o,
  input logic  eoc_oe,
  input byte_t db_o,
  input byte_t db_oe,
  input logic  byte_hi
);
  AST_SYNC_CS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && sync_mode) |-> !cs_s); // R1
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_evt)); // R4
  AST_SYNC_STATUS_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && eoc_oe) |-> (eoc_o == !busy)); // R5
  AST_ASYNC_PULLDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_mode && eoc_oe) |-> (!eoc_o && busy)); // R6
  AST_LOW_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (db_oe[0] && byte_hi) |-> (db_o[1:0] == 2'b00)); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_evt |=> $stable(result_q)); // R10
  AST_NO_START_MIDCONV: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done_evt) |-> !start_evt); // R11
  AST_PWRUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |-> !start_evt); // R12
endmodule

bind sadc_bus_if sadc_bus_if_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sync_mode (sync_mode),
  .cs_s      (cs_sync),
  .start_evt (start_evt),
  .done_evt  (done_evt),
  .busy      (busy),
  .pwr_ok    (pwr_ok),
  .result_q  (result_q),
  .eoc_o     (eoc_o),
  .eoc_oe    (eoc_oe),
  .db_o      (db_o),
  .db_oe     (db_oe),
  .byte_hi   (byte_hi)
);

// File: tb/sadc_bus_if_tb.sv
`timescale 1ns/1ps
module sadc_bus_if_tb_top;
  localparam int C  = 315;
  localparam int PU = 500;

  logic clk = 1'b0;
  logic rst_n, sync_mode, bipolar, cs_n, sc_n, stat_en_n, oe_n, byte_hi;
  logic [13:0] core_code;
  logic eoc_o, eoc_oe, cont_warn;
  logic [7:0] db_o, db_oe;

  int checks = 0;
  int errs   = 0;

  always #10 clk = ~clk;

  sadc_bus_if #(.CONV_CYCLES(C), .PWRUP_CYCLES(PU)) dut_i (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .bipolar(bipolar),
    .cs_n(cs_n), .sc_n(sc_n), .stat_en_n(stat_en_n), .oe_n(oe_n),
    .byte_hi(byte_hi), .core_code(core_code), .eoc_o(eoc_o), .eoc_oe(eoc_oe),
    .db_o(db_o), .db_oe(db_oe), .cont_warn(cont_warn)
  );

  // {bipolar, core_code, expected high byte, expected low byte}
  localparam logic [30:0] VECS [10] = '{
    {1'b0, 14'h0000, 8'h00, 8'h00},
    {1'b0, 14'h3FFF, 8'hFF, 8'hFC},
    {1'b0, 14'h2000, 8'h80, 8'h00},
    {1'b0, 14'h1555, 8'h55, 8'h54},
    {1'b1, 14'h0000, 8'h80, 8'h00},
    {1'b1, 14'h2000, 8'h00, 8'h00},
    {1'b1, 14'h3FFF, 8'h7F, 8'hFC},
    {1'b1, 14'h1FFF, 8'hFF, 8'hFC},
    {1'b1, 14'h2AB3, 8'h2A, 8'hCC},
    {1'b0, 14'h2AB3, 8'hAA, 8'hCC}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic hi, output logic [7:0] v, output logic en);
    byte_hi = hi;
    oe_n    = 1'b0;
    #2;
    v  = db_o;
    en = db_oe[0];
    oe_n = 1'b1;
    #1;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic en;
    rst_n = 0; sync_mode = 1; bipolar = 0; cs_n = 0; sc_n = 1;
    stat_en_n = 0; oe_n = 1; byte_hi = 0; core_code = '0;
    tick(5);
    rst_n = 1;
    tick(1);
    // Reset state
    chk("R5 reset status enabled", eoc_oe, 1);
    chk("R4 reset status idle", eoc_o, 1);
    chk("R7 reset bus float", db_oe, 0);
    chk("R3 reset warn", cont_warn, 0);
    rd(1'b0, b, en);
    chk("R8 reset result high byte", b, 8'h00);

    // R12: strobe during power-up is ignored
    tick(10);
    sc_n = 0; tick(5); sc_n = 1; tick(10);
    chk("R12 no start in power-up", eoc_o, 1);
    tick(PU);

    // R4 timing and R10 atomic update (sync mode, cs low)
    core_code = 14'h1555;
    sc_n = 0;                       // negedge N
    tick(2);
    chk("R4 status still idle at N+2", eoc_o, 1);
    tick(1);
    chk("R4 status low at N+3", eoc_o, 0);
    tick(2); sc_n = 1;              // N+5
    tick(C - 3);                    // N+2+C
    chk("R4 status low on last busy cycle", eoc_o, 0);
    rd(1'b0, b, en);
    chk("R10 read during conversion keeps old", b, 8'h00);
    tick(1);                        // N+3+C
    chk("R4 status high after CONV_CYCLES", eoc_o, 1);
    rd(1'b0, b, en);
    chk("R10 new result at end edge", b, 8'h55);

    // R11: second strobe mid-conversion ignored
    tick(2);
    sc_n = 0; tick(5); sc_n = 1;    // N..N+5
    tick(40); sc_n = 0; tick(5); sc_n = 1; // N+50
    tick(C - 48);                   // N+2+C
    chk("R11 length unchanged (still busy)", eoc_o, 0);
    tick(1);
    chk("R11 ends on time", eoc_o, 1);
    tick(10);
    chk("R11 no follow-on conversion", eoc_o, 1);

    // R1 / R5: chip select high blocks start and floats status
    cs_n = 1; tick(4);
    chk("R5 status floats with cs high", eoc_oe, 0);
    sc_n = 0; tick(5); sc_n = 1; tick(4);
    cs_n = 0; tick(4);
    chk("R1 no start with cs high", eoc_o, 1);
    stat_en_n = 1; #2;
    chk("R5 status floats with enable high", eoc_oe, 0);
    stat_en_n = 0; #1;
    chk("R5 status driven with cs and enable low", eoc_oe, 1);

    // R2 / R6: async mode
    tick(1);
    sync_mode = 0; cs_n = 1; tick(2);
    chk("R6 async idle floats", eoc_oe, 0);
    sc_n = 0; tick(3);
    chk("R2 async start ignores cs (drive)", eoc_oe, 1);
    chk("R6 async drives low", eoc_o, 0);
    tick(2); sc_n = 1; tick(5);
    stat_en_n = 1; #2;
    chk("R6 enable high floats mid-conversion", eoc_oe, 0);
    stat_en_n = 0; #1;
    oe_n = 0; #2;
    chk("R7 cs high blocks bus", db_oe, 0);
    oe_n = 1; cs_n = 0; #2;
    chk("R7 oe high blocks bus", db_oe, 0);
    tick(C + 5);
    chk("R6 async floats after end", eoc_oe, 0);

    // R3: held-low strobe, back to back (sync mode)
    sync_mode = 1; core_code = 14'h0F0F; tick(4);
    sc_n = 0;                       // N
    tick(3 + C);                    // N+3+C
    chk("R3 status stays low across restart", eoc_o, 0);
    chk("R3 warn raised", cont_warn, 1);
    rd(1'b0, b, en);
    chk("R3 first result", b, 8'h3C);
    core_code = 14'h3A5C;
    tick(C);                        // N+3+2C
    rd(1'b0, b, en);
    chk("R3 second result", b, 8'hE9);
    sc_n = 1; tick(5);
    chk("R3 warn cleared", cont_warn, 0);
    tick(C + 5);
    chk("R3 idle after release", eoc_o, 1);

    // R8 / R9 vector walk in async mode
    sync_mode = 0; cs_n = 0;
    for (int i = 0; i < 10; i++) begin
      bipolar   = VECS[i][30];
      core_code = VECS[i][29:16];
      tick(2);
      sc_n = 0; tick(4); sc_n = 1;
      tick(C + 4);
      rd(1'b0, b, en);
      chk("R7 bus enabled on read", en, 1);
      chk("R9 R8 high byte", b, VECS[i][15:8]);
      rd(1'b1, b, en);
      chk("R9 R8 low byte with padding", b, VECS[i][7:0]);
      tick(1);
    end

    summary();
    $finish;
  end
endmodule